// File: doc/BRIEF.md
# Fetch Address Sequencer

This block owns the program counter of a small core with 16-bit instruction words and a 21-bit byte-addressed program space. Every cycle it presents a fetch address. When the decoder marks the word on the fetch bus as consumed, the block works out the next address. It either steps to the following word, or assembles the target of a two-word absolute jump, or adds a signed word offset for a one-word relative branch.

Each redirect is followed by exactly one bubble cycle. In that cycle the word on the bus belongs to the discarded prefetch and has no effect. The same redirect path serves the two interrupt entry points. An orphaned tail word of an absolute jump is flagged so that the core can treat it as a no-op.

The counter holds byte addresses, so word addresses are always even and each sequential step adds 2. Arithmetic wraps at 2^21.

Top module: `pcseq_top`

## Requirements
- R1: While reset is asserted, and at the first cycle after it, `fetch_addr` is 0x000000 and `flush` is 0. A reset taken between the two words of an absolute jump abandons the jump.
- R2: In a normal cycle with no accepted interrupt, a consumed word that is not a branch moves `fetch_addr` up by 2 at the next edge. A cycle with `word_valid` low leaves it unchanged.
- R3: A consumed word with upper byte 0xEF starts an absolute jump. Its low byte is kept as target bits [7:0], and the address steps by 2 to fetch the tail. The next consumed word supplies target bits [19:8] from its low 12 bits. The byte target is that 20-bit field shifted left by one, so 0xEF05 followed by 0xF000 lands on 0x00000A.
- R4: A consumed word whose bits [15:11] are 11010 is a relative branch. Its bits [10:0] form a two's-complement word offset n, and the target is its own address + 2 + 2·n. For example, 0xD7F5 at 0x34 goes to 0x20.
- R5: After any redirect, `flush` is 1 for exactly one cycle and `fetch_addr` already shows the target. The word presented during that cycle is ignored, and `fetch_addr` does not move across it.
- R6: A consumed word with top nibble 0xF, reached in a normal cycle rather than as the tail of an absolute jump, raises `tail_nop` in that same cycle and steps the address by 2.
- R7: In a normal cycle, a pending interrupt replaces the current word and redirects with a flush. `irq_hi` goes to 0x000008. `irq_lo` goes to 0x000018 when `prio_en` is 1, and to 0x000008 when `prio_en` is 0. Acceptance does not depend on `word_valid`.
- R8: When `irq_hi` and `irq_lo` are both high in the same cycle, the high-priority vector 0x000008 is taken.
- R9: Interrupt requests are not accepted in a flush cycle or while the tail of an absolute jump is awaited. They are taken at the first normal cycle in which they are still asserted.
- R10: Address arithmetic wraps modulo 2^21. A step from 0x1FFFFE gives 0x000000, and a backward branch below zero wraps to the top of the space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_word | input | 16 | Word read from program memory at `fetch_addr` |
| word_valid | input | 1 | Decoder consumes the word on `fetch_word` this cycle |
| irq_hi | input | 1 | High-priority interrupt request |
| irq_lo | input | 1 | Low-priority interrupt request |
| prio_en | input | 1 | Separate low-priority vector enabled |
| fetch_addr | output | 21 | Current byte fetch address |
| flush | output | 1 | Bubble cycle: decoder must ignore `fetch_word` |
| tail_nop | output | 1 | Current word is an orphaned jump tail, run as no-op |

## Verification
`tail_nop` is a same-cycle result: it follows the word and the state of the current cycle. A new `fetch_addr` appears one clock edge after the word or interrupt that causes it, and `flush` rises at that same edge and clears at the next one. The bench drives inputs at the falling edge and checks all three outputs shortly after. At that point each row's expected address is the effect of the previous row's stimulus, and the expected `tail_nop` is the effect of the current row. Some rows place a real branch or tail word inside a bubble cycle, which shows that the next address ignores it.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
    parameter int PC_W      = 21;
    parameter int WORD_W    = 16;
    parameter int LO_FIELD  = 8;
    parameter int HI_FIELD  = 12;
    parameter int OFS_W     = 11;
    parameter int STEP      = 2;

    localparam logic [PC_W-1:0] VEC_RESET = 21'h000000;
    localparam logic [PC_W-1:0] VEC_HIGH  = 21'h000008;
    localparam logic [PC_W-1:0] VEC_LOW   = 21'h000018;

    localparam logic [7:0] OPC_ABS  = 8'hEF;
    localparam logic [4:0] OPC_REL  = 5'b11010;
    localparam logic [3:0] OPC_TAIL = 4'hF;

    typedef enum logic [1:0] {
        SQ_RUN  = 2'd0,
        SQ_TAIL = 2'd1,
        SQ_BUB  = 2'd2
    } seq_e;

    typedef struct packed {
        seq_e                  st;
        logic [PC_W-1:0]       pc;
        logic [LO_FIELD-1:0]   lo;
    } seq_t;
endpackage

// File: rtl/pcseq_decode.sv
module pcseq_decode
    import pcseq_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output logic              is_abs,
    output logic              is_rel,
    output logic              is_tail
);
    always_comb begin
        is_abs  = (word[WORD_W-1 -: 8] == OPC_ABS);
        is_rel  = (word[WORD_W-1 -: 5] == OPC_REL);
        is_tail = (word[WORD_W-1 -: 4] == OPC_TAIL);
    end
endmodule

// File: rtl/pcseq_target.sv
module pcseq_target
    import pcseq_pkg::*;
(
    input  logic [PC_W-1:0]     pc,
    input  logic [WORD_W-1:0]   word,
    input  logic [LO_FIELD-1:0] lo,
    output logic [PC_W-1:0]     abs_tgt,
    output logic [PC_W-1:0]     rel_tgt,
    output logic [PC_W-1:0]     seq_tgt
);
    localparam int FIELD_W = HI_FIELD + LO_FIELD;

    logic [FIELD_W-1:0] word_field;
    logic [PC_W-1:0]    ofs_ext;

    always_comb begin
        word_field = {word[HI_FIELD-1:0], lo};
        abs_tgt    = PC_W'({word_field, 1'b0});
        ofs_ext    = {{(PC_W-OFS_W){word[OFS_W-1]}}, word[OFS_W-1:0]};
        seq_tgt    = pc + PC_W'(STEP);
        rel_tgt    = seq_tgt + (ofs_ext << 1);
    end
endmodule

// File: rtl/pcseq_vector.sv
module pcseq_vector
    import pcseq_pkg::*;
(
    input  logic            irq_hi,
    input  logic            irq_lo,
    input  logic            prio_en,
    output logic            take,
    output logic [PC_W-1:0] vec
);
    always_comb begin
        take = irq_hi | irq_lo;
        if (irq_hi || !prio_en) vec = VEC_HIGH;
        else                    vec = VEC_LOW;
    end
endmodule

// File: rtl/pcseq_top.sv
module pcseq_top
    import pcseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] fetch_word,
    input  logic              word_valid,
    input  logic              irq_hi,
    input  logic              irq_lo,
    input  logic              prio_en,
    output logic [PC_W-1:0]   fetch_addr,
    output logic              flush,
    output logic              tail_nop
);
    seq_t seq_d, seq_q;

    logic            dec_abs, dec_rel, dec_tail;
    logic [PC_W-1:0] tgt_abs, tgt_rel, tgt_seq;
    logic            irq_take;
    logic [PC_W-1:0] irq_vec;
    logic            run_irq;
    logic            run_word;

    pcseq_decode u_dec (
        .word    (fetch_word),
        .is_abs  (dec_abs),
        .is_rel  (dec_rel),
        .is_tail (dec_tail)
    );

    pcseq_target u_tgt (
        .pc      (seq_q.pc),
        .word    (fetch_word),
        .lo      (seq_q.lo),
        .abs_tgt (tgt_abs),
        .rel_tgt (tgt_rel),
        .seq_tgt (tgt_seq)
    );

    pcseq_vector u_vec (
        .irq_hi  (irq_hi),
        .irq_lo  (irq_lo),
        .prio_en (prio_en),
        .take    (irq_take),
        .vec     (irq_vec)
    );

    always_comb begin
        seq_d    = seq_q;
        run_irq  = (seq_q.st == SQ_RUN) && irq_take;
        run_word = (seq_q.st == SQ_RUN) && !irq_take && word_valid;
        tail_nop = run_word && dec_tail;
        unique case (seq_q.st)
            SQ_RUN: begin
                if (irq_take) begin
                    seq_d.pc = irq_vec;
                    seq_d.st = SQ_BUB;
                end else if (word_valid) begin
                    if (dec_abs) begin
                        seq_d.lo = fetch_word[LO_FIELD-1:0];
                        seq_d.pc = tgt_seq;
                        seq_d.st = SQ_TAIL;
                    end else if (dec_rel) begin
                        seq_d.pc = tgt_rel;
                        seq_d.st = SQ_BUB;
                    end else begin
                        seq_d.pc = tgt_seq;
                    end
                end
            end
            SQ_TAIL: begin
                if (word_valid) begin
                    seq_d.pc = tgt_abs;
                    seq_d.st = SQ_BUB;
                end
            end
            SQ_BUB: begin
                seq_d.st = SQ_RUN;
            end
            default: begin
                seq_d.st = SQ_RUN;
            end
        endcase
        fetch_addr = seq_q.pc;
        flush      = (seq_q.st == SQ_BUB);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st <= SQ_RUN;
            seq_q.pc <= VEC_RESET;
            seq_q.lo <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    AST_ADDR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_addr[0] == 1'b0);                                                   // R2
    AST_STEP_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
        run_word && !dec_abs && !dec_rel |=> fetch_addr == $past(fetch_addr) + PC_W'(STEP)); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !flush && !word_valid && !irq_take |=> $stable(fetch_addr));             // R2
    AST_BUBBLE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !flush);                                                         // R5
    AST_BUBBLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> $stable(fetch_addr));                                            // R5
    AST_NOP_NOT_IN_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        tail_nop |-> !flush);                                                      // R6
    AST_HIGH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        !flush && seq_q.st == SQ_RUN && irq_hi |=> flush && fetch_addr == VEC_HIGH); // R8
    AST_BUBBLE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        flush && irq_hi |=> !flush);                                               // R9
endmodule

// File: tb/sim_pcseq_top.sv
module sim_pcseq_top;
    import pcseq_pkg::*;

    typedef struct packed {
        logic        v;
        logic [15:0] w;
        logic        hi;
        logic        lo;
        logic        pr;
        logic [20:0] a;
        logic        f;
        logic        n;
        logic [3:0]  rq;
    } row_t;

    localparam int NROWS = 38;
    localparam row_t ROWS [NROWS] = '{
        '{1'b1, 16'h0E55, 1'b0, 1'b0, 1'b0, 21'h000000, 1'b0, 1'b0, 4'd2},
        '{1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 21'h000002, 1'b0, 1'b0, 4'd2},
        '{1'b1, 16'hEF05, 1'b0, 1'b0, 1'b0, 21'h000002, 1'b0, 1'b0, 4'd3},
        '{1'b1, 16'hF000, 1'b0, 1'b0, 1'b0, 21'h000004, 1'b0, 1'b0, 4'd3},
        '{1'b1, 16'h1234, 1'b0, 1'b0, 1'b0, 21'h00000A, 1'b1, 1'b0, 4'd5},
        '{1'b1, 16'h0E55, 1'b0, 1'b0, 1'b0, 21'h00000A, 1'b0, 1'b0, 4'd2},
        '{1'b1, 16'hEF1A, 1'b0, 1'b0, 1'b0, 21'h00000C, 1'b0, 1'b0, 4'd3},
        '{1'b1, 16'hF000, 1'b0, 1'b0, 1'b0, 21'h00000E, 1'b0, 1'b0, 4'd3},
        '{1'b1, 16'hD7F5, 1'b0, 1'b0, 1'b0, 21'h000034, 1'b1, 1'b0, 4'd5},
        '{1'b1, 16'hD7F5, 1'b0, 1'b0, 1'b0, 21'h000034, 1'b0, 1'b0, 4'd4},
        '{1'b1, 16'hF0F0, 1'b0, 1'b0, 1'b0, 21'h000020, 1'b1, 1'b0, 4'd5},
        '{1'b1, 16'hF123, 1'b0, 1'b0, 1'b0, 21'h000020, 1'b0, 1'b1, 4'd6},
        '{1'b1, 16'hD005, 1'b0, 1'b0, 1'b0, 21'h000022, 1'b0, 1'b0, 4'd4},
        '{1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, 21'h00002E, 1'b1, 1'b0, 4'd5},
        '{1'b1, 16'hD7F5, 1'b0, 1'b0, 1'b0, 21'h00002E, 1'b0, 1'b0, 4'd4},
        '{1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, 21'h00001A, 1'b1, 1'b0, 4'd5},
        '{1'b1, 16'h0E55, 1'b1, 1'b0, 1'b0, 21'h00001A, 1'b0, 1'b0, 4'd7},
        '{1'b1, 16'h0000, 1'b0, 1'b1, 1'b1, 21'h000008, 1'b1, 1'b0, 4'd9},
        '{1'b1, 16'h0E55, 1'b0, 1'b1, 1'b1, 21'h000008, 1'b0, 1'b0, 4'd7},
        '{1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, 21'h000018, 1'b1, 1'b0, 4'd5},
        '{1'b1, 16'h0E55, 1'b0, 1'b1, 1'b0, 21'h000018, 1'b0, 1'b0, 4'd7},
        '{1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, 21'h000008, 1'b1, 1'b0, 4'd5},
        '{1'b1, 16'h0E55, 1'b0, 1'b0, 1'b0, 21'h000008, 1'b0, 1'b0, 4'd2},
        '{1'b1, 16'h0E55, 1'b1, 1'b1, 1'b1, 21'h00000A, 1'b0, 1'b0, 4'd8},
        '{1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, 21'h000008, 1'b1, 1'b0, 4'd8},
        '{1'b1, 16'hEF00, 1'b0, 1'b0, 1'b0, 21'h000008, 1'b0, 1'b0, 4'd3},
        '{1'b1, 16'hF001, 1'b1, 1'b0, 1'b0, 21'h00000A, 1'b0, 1'b0, 4'd9},
        '{1'b1, 16'h0000, 1'b1, 1'b0, 1'b0, 21'h000200, 1'b1, 1'b0, 4'd9},
        '{1'b1, 16'h0E55, 1'b1, 1'b0, 1'b0, 21'h000200, 1'b0, 1'b0, 4'd9},
        '{1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, 21'h000008, 1'b1, 1'b0, 4'd5},
        '{1'b1, 16'hEFFF, 1'b0, 1'b0, 1'b0, 21'h000008, 1'b0, 1'b0, 4'd3},
        '{1'b1, 16'hFFFF, 1'b0, 1'b0, 1'b0, 21'h00000A, 1'b0, 1'b0, 4'd3},
        '{1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, 21'h1FFFFE, 1'b1, 1'b0, 4'd5},
        '{1'b1, 16'h0E55, 1'b0, 1'b0, 1'b0, 21'h1FFFFE, 1'b0, 1'b0, 4'd10},
        '{1'b1, 16'hD7F5, 1'b0, 1'b0, 1'b0, 21'h000000, 1'b0, 1'b0, 4'd10},
        '{1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, 21'h1FFFEC, 1'b1, 1'b0, 4'd10},
        '{1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 21'h1FFFEC, 1'b0, 1'b0, 4'd2},
        '{1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 21'h1FFFEC, 1'b0, 1'b0, 4'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] fetch_word = '0;
    logic        word_valid = 1'b0;
    logic        irq_hi = 1'b0;
    logic        irq_lo = 1'b0;
    logic        prio_en = 1'b0;
    logic [20:0] fetch_addr;
    logic        flush;
    logic        tail_nop;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    pcseq_top u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_word (fetch_word),
        .word_valid (word_valid),
        .irq_hi     (irq_hi),
        .irq_lo     (irq_lo),
        .prio_en    (prio_en),
        .fetch_addr (fetch_addr),
        .flush      (flush),
        .tail_nop   (tail_nop)
    );

    function automatic string tag(input int k);
        case (k)
            1:       return "R1";
            2:       return "R2";
            3:       return "R3";
            4:       return "R4";
            5:       return "R5";
            6:       return "R6";
            7:       return "R7";
            8:       return "R8";
            9:       return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [15:0] w,
                         input logic hi, input logic lo, input logic pr);
        word_valid = v;
        fetch_word = w;
        irq_hi     = hi;
        irq_lo     = lo;
        prio_en    = pr;
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: state during reset
        repeat (2) @(negedge clk);
        #1;
        check("R1", "fetch_addr in reset", 32'(fetch_addr), 32'h0);
        check("R1", "flush in reset", 32'(flush), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1", "fetch_addr after release", 32'(fetch_addr), 32'h0);

        for (int i = 0; i < NROWS; i++) begin
            @(negedge clk);
            drive(ROWS[i].v, ROWS[i].w, ROWS[i].hi, ROWS[i].lo, ROWS[i].pr);
            #1;
            check(tag(int'(ROWS[i].rq)), "fetch_addr", 32'(fetch_addr), 32'(ROWS[i].a));
            check(tag(int'(ROWS[i].rq)), "flush", 32'(flush), 32'(ROWS[i].f));
            check(tag(int'(ROWS[i].rq)), "tail_nop", 32'(tail_nop), 32'(ROWS[i].n));
        end

        // R1 + R6: reset between the two words of an absolute jump
        @(negedge clk);
        drive(1'b1, 16'hEF40, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        drive(1'b0, 16'h0000, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b0;
        #1;
        check("R1", "fetch_addr mid-jump reset", 32'(fetch_addr), 32'h0);
        check("R1", "flush mid-jump reset", 32'(flush), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        drive(1'b1, 16'hF001, 1'b0, 1'b0, 1'b0);
        #1;
        check("R6", "tail_nop on orphan after reset", 32'(tail_nop), 32'h1);
        @(negedge clk);
        drive(1'b0, 16'h0000, 1'b0, 1'b0, 1'b0);
        #1;
        check("R6", "orphan tail steps by 2", 32'(fetch_addr), 32'h2);
        check("R6", "orphan tail no flush", 32'(flush), 32'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule